// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external pins and raises a per-channel interrupt flag when a pin shows a chosen edge or level. Each pin first crosses into the block clock domain through a two-flop synchroniser. It can then pass through an optional glitch filter that takes the 2-of-3 majority of three consecutive samples. Last comes a detector that looks for a rising edge, a falling edge, either edge, a high level or a low level. All channel flags are ORed into a single interrupt request.

Software drives the block through a small 32-bit register port with three addresses: a control word holding the global enable, a configuration word with one 4-bit field per channel, and the flag word. Writing 1 to a bit of the flag word clears that bit. The configuration is locked while the block is enabled, and only full-width writes are accepted. While the block is disabled, its edge history follows the pins, so turning it on does not report an edge that happened earlier.

Top module: `eint_sense_ctrl`

## Requirements
- R1: After reset, the control word, the configuration word and all flags are zero, `irq` is 0 and `rd_data` is 0.
- R2: Channel k uses configuration bits [4k+2:4k] as its sense code and bit 4k+3 as its filter enable. A value written while disabled reads back unchanged.
- R3: With the filter off, sense code 1 sets the flag on a rising pin, code 2 on a falling pin and code 3 on either edge. The flag shows 4 clock edges after the pin changes. Edge flags stay set until they are cleared.
- R4: Sense code 4 holds the flag high while the filtered pin is 1, and code 5 holds it high while the pin is 0. The flag drops when the level goes away, and a clear write has no effect while the level persists.
- R5: Sense codes 0, 6 and 7 never set a flag.
- R6: With the filter on, a pin pulse of one cycle is rejected and a pulse of two or more cycles is detected. An edge flag then shows 5 clock edges after the pin changes.
- R7: A configuration write made while the enable bit is 1 is ignored.
- R8: Any write whose byte enables are not all ones is ignored, at every address.
- R9: A full write to the flag address clears each flag whose data bit is 1. A new edge in the same cycle wins over the clear.
- R10: While the enable bit is 0, no flag is set and no level flag is held. Enabling the block while a pin is already high does not produce a rising-edge flag.
- R11: `irq` is 1 exactly when at least one bit of `irq_flags` is 1.
- R12: The read port has one cycle of latency. Address 0 returns the enable in bit 0, address 1 the configuration word, address 2 the flags in bits [NUM_CH-1:0], and address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 configuration, 2 flags) |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables; only 4'hF is accepted |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data, one cycle after `rd_addr` |
| pins_i | input | 8 | Asynchronous external pins, one per channel |
| irq_flags | output | 8 | Per-channel interrupt flags |
| irq | output | 1 | OR of all channel flags |

## Verification
When the filter is off, a pin change shows on its flag at the fourth rising clock edge after the change. With the filter on, it shows at the fifth. Register writes take effect at the next edge, and read data is due one edge after the address is presented. The bench drives every input on the falling clock edge and counts the rising edges between the stimulus and the sample. The exact-latency tests check that the flag is still clear one edge before it is due and set on the edge it is due. The sweep over all channels and all eight sense codes waits well beyond the latency before each check, so it tests the function and not the timing.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int ADDR_W  = 2;
  localparam int FIELD_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

  typedef enum logic [2:0] {
    SENSE_OFF      = 3'd0,
    SENSE_RISE     = 3'd1,
    SENSE_FALL     = 3'd2,
    SENSE_ANY_EDGE = 3'd3,
    SENSE_HIGH     = 3'd4,
    SENSE_LOW      = 3'd5
  } sense_e;
endpackage

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 8,
  localparam int CFG_W = NUM_CH * FIELD_W,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NUM_CH-1:0] flags_i,
  output logic              en_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [NUM_CH-1:0] clr_o,
  output logic [DATA_W-1:0] rd_data
);
  logic              full_wr;
  logic [DATA_W-1:0] rd_mux;

  assign full_wr = wr_en && (wr_be == {BE_W{1'b1}});

  // Write-one-to-clear pulses for the channel flags.
  assign clr_o = (full_wr && wr_addr == ADDR_FLAG) ? wr_data[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o  <= 1'b0;
      cfg_o <= '0;
    end else if (full_wr) begin
      if (wr_addr == ADDR_CTRL) en_o <= wr_data[0];
      // Configuration is frozen while the block runs.
      if (wr_addr == ADDR_CFG && !en_o) cfg_o <= wr_data[CFG_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      ADDR_CTRL: rd_mux[0]          = en_o;
      ADDR_CFG:  rd_mux[CFG_W-1:0]  = cfg_o;
      ADDR_FLAG: rd_mux[NUM_CH-1:0] = flags_i;
      default:   rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/eint_chan.sv
module eint_chan
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       pin_i,
  input  logic [2:0] mode_i,
  input  logic       filt_en_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic                   filt_q;
  logic                   prev_q;
  logic                   s_pin;
  logic                   vote;
  logic                   rise;
  logic                   fall;
  logic                   flag_nxt;

  assign s_pin = sync_q[SYNC_STAGES-1];
  // 2-of-3 majority over the current and two previous samples.
  assign vote  = (s_pin & hist_q[0]) | (s_pin & hist_q[1]) | (hist_q[0] & hist_q[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      if (!en_i) begin
        // Track the pin so that enabling sees no stale edge.
        hist_q <= {s_pin, s_pin};
        filt_q <= s_pin;
        prev_q <= s_pin;
      end else begin
        hist_q <= {hist_q[0], s_pin};
        filt_q <= filt_en_i ? vote : s_pin;
        prev_q <= filt_q;
      end
    end
  end

  assign rise = filt_q & ~prev_q;
  assign fall = ~filt_q & prev_q;

  always_comb begin
    unique case (mode_i)
      SENSE_RISE:     flag_nxt = (en_i & rise) | (flag_o & ~clr_i);
      SENSE_FALL:     flag_nxt = (en_i & fall) | (flag_o & ~clr_i);
      SENSE_ANY_EDGE: flag_nxt = (en_i & (rise | fall)) | (flag_o & ~clr_i);
      SENSE_HIGH:     flag_nxt = en_i & filt_q;
      SENSE_LOW:      flag_nxt = en_i & ~filt_q;
      default:        flag_nxt = flag_o & ~clr_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_nxt;
  end
endmodule

// File: rtl/eint_sense_ctrl.sv
module eint_sense_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_CH-1:0]   pins_i,
  output logic [NUM_CH-1:0]   irq_flags,
  output logic                irq
);
  localparam int CFG_W = NUM_CH * FIELD_W;

  logic              en_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [NUM_CH-1:0] clr;

  eint_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .rd_addr (rd_addr),
    .flags_i (irq_flags),
    .en_o    (en_q),
    .cfg_o   (cfg_q),
    .clr_o   (clr),
    .rd_data (rd_data)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    eint_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .en_i      (en_q),
      .pin_i     (pins_i[k]),
      .mode_i    (cfg_q[FIELD_W*k +: 3]),
      .filt_en_i (cfg_q[FIELD_W*k + 3]),
      .clr_i     (clr[k]),
      .flag_o    (irq_flags[k])
    );
  end

  assign irq = |irq_flags;
endmodule

// File: rtl/eint_sva.sv
module eint_sva #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [1:0]          wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W/8-1:0] wr_be,
  input logic                en_q,
  input logic [NUM_CH*4-1:0] cfg_q,
  input logic [NUM_CH-1:0]   irq_flags
);
  // R7: configuration never moves while enabled
  a_r7_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(cfg_q));

  // R8: partial writes leave control and configuration alone
  a_r8_partial_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be != {(DATA_W/8){1'b1}}) |=> ($stable(cfg_q) && $stable(en_q)));

  // R10: nothing new appears while disabled
  a_r10_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> ((irq_flags & ~$past(irq_flags)) == '0));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_k
    // R5: codes 0, 6, 7 never raise a flag
    a_r5_no_sense: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[4*k +: 3] == 3'd0 || cfg_q[4*k +: 3] >= 3'd6) |=> !$rose(irq_flags[k]));

    // R9: an edge flag persists until a clear names it
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[4*k +: 3] >= 3'd1 && cfg_q[4*k +: 3] <= 3'd3 && irq_flags[k] &&
       !(wr_en && wr_be == {(DATA_W/8){1'b1}} && wr_addr == 2'd2 && wr_data[k]))
      |=> irq_flags[k]);
  end
endmodule

bind eint_sense_ctrl eint_sva #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_be     (wr_be),
  .en_q      (en_q),
  .cfg_q     (cfg_q),
  .irq_flags (irq_flags)
);

// File: tb/test_eint_sense_ctrl.sv
`timescale 1ns/1ps
module test_eint_sense_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  pins_i = '0;
  logic [7:0]  irq_flags;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eint_sense_ctrl i_eint_sense_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data), .pins_i(pins_i),
    .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic chk_flags(input logic [7:0] exp, input string req);
    chk(irq_flags == exp, req, {24'd0, irq_flags}, {24'd0, exp});
    chk(irq == (exp != 0), "R11", {31'd0, irq}, {31'd0, (exp != 0)});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  e;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk_flags(8'h00, "R1");
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 cfg", v, 0);

    // R2 layout readback, R12 addresses
    wr(2'd1, 32'h89AB_CDEF, 4'hF);
    rd(2'd1, v); chk(v == 32'h89AB_CDEF, "R2 readback", v, 32'h89AB_CDEF);
    rd(2'd3, v); chk(v == 0, "R12 addr3", v, 0);
    // R8 partial writes ignored
    wr(2'd1, 32'h1111_1111, 4'h7);
    rd(2'd1, v); chk(v == 32'h89AB_CDEF, "R8 cfg partial", v, 32'h89AB_CDEF);
    wr(2'd0, 32'h1, 4'hE);
    rd(2'd0, v); chk(v == 0, "R8 ctrl partial", v, 0);
    // R7 lock
    wr(2'd1, 32'h0, 4'hF);
    wr(2'd0, 32'h1, 4'hF);
    rd(2'd0, v); chk(v == 1, "R12 ctrl", v, 1);
    wr(2'd1, 32'h5555_5555, 4'hF);
    rd(2'd1, v); chk(v == 0, "R7 locked", v, 0);
    wr(2'd0, 32'h0, 4'hF);

    // R2/R3/R4/R5 sweep: every channel, every code
    for (int k = 0; k < 8; k++) begin
      for (int m = 0; m < 8; m++) begin
        wr(2'd0, 32'h0, 4'hF);
        pins_i = '0;
        wr(2'd2, 32'hFF, 4'hF);
        wr(2'd1, 32'(m) << (4*k), 4'hF);
        wr(2'd0, 32'h1, 4'hF);
        idle(6);
        e = (m == 5) ? 8'(1 << k) : 8'h0;
        chk_flags(e, "R4/R5 low start");
        pins_i[k] = 1'b1;
        idle(6);
        e = (m == 1 || m == 3 || m == 4) ? 8'(1 << k) : 8'h0;
        chk_flags(e, "R2/R3/R4/R5 rise");
        rd(2'd2, v); chk(v == {24'd0, e}, "R12 flag read", v, {24'd0, e});
        wr(2'd2, 32'hFF, 4'hF);
        idle(1);
        e = (m == 4) ? 8'(1 << k) : 8'h0;
        chk_flags(e, "R4/R9 clear");
        pins_i[k] = 1'b0;
        idle(6);
        e = (m == 2 || m == 3 || m == 5) ? 8'(1 << k) : 8'h0;
        chk_flags(e, "R3/R4/R5 fall");
      end
    end

    // R3 exact latency, unfiltered rising edge on channel 0
    wr(2'd0, 32'h0, 4'hF); pins_i = '0;
    wr(2'd2, 32'hFF, 4'hF);
    wr(2'd1, 32'h1, 4'hF);
    wr(2'd0, 32'h1, 4'hF);
    idle(6);
    pins_i[0] = 1'b1;
    idle(3); chk_flags(8'h00, "R3 early");
    idle(1); chk_flags(8'h01, "R3 due");

    // R6 filtered: latency and glitch rejection
    wr(2'd0, 32'h0, 4'hF); pins_i = '0;
    wr(2'd2, 32'hFF, 4'hF);
    wr(2'd1, 32'h9, 4'hF);
    wr(2'd0, 32'h1, 4'hF);
    idle(6);
    pins_i[0] = 1'b1;
    idle(4); chk_flags(8'h00, "R6 early");
    idle(1); chk_flags(8'h01, "R6 due");
    pins_i[0] = 1'b0; idle(6);
    wr(2'd2, 32'hFF, 4'hF);
    pins_i[0] = 1'b1; idle(1); pins_i[0] = 1'b0;
    idle(8); chk_flags(8'h00, "R6 glitch");
    pins_i[0] = 1'b1; idle(2); pins_i[0] = 1'b0;
    idle(8); chk_flags(8'h01, "R6 two-cycle pulse");

    // R9 partial clear write ignored, selective clear
    wr(2'd2, 32'hFF, 4'h3);
    idle(1); chk_flags(8'h01, "R8/R9 partial clear");
    wr(2'd2, 32'hFE, 4'hF);
    idle(1); chk_flags(8'h01, "R9 other bit");

    // R10 disabled: no flags, no false edge on enable
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd2, 32'hFF, 4'hF);
    wr(2'd1, 32'h0000_0041, 4'hF); // ch0 rise, ch1 high
    pins_i = 8'h03;
    idle(6); chk_flags(8'h00, "R10 disabled");
    wr(2'd0, 32'h1, 4'hF);
    idle(6); chk_flags(8'h02, "R10 no false edge");
    wr(2'd0, 32'h0, 4'hF);
    idle(1); chk_flags(8'h00, "R10 level drops");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule